// File: doc/BRIEF.md
# Tile-Map Pixel Fetcher

This block turns a grid of tile references into a stream of monochrome pixels. The screen is divided into square tiles, 8x8 pixels by default. A map of 80 columns by 60 rows holds one 16-bit reference per tile, stored as two bytes. The reference selects a bitmap held in a second memory, the shape store. Only the map is writable from the processor side. Rewriting one two-byte entry therefore repaints a whole tile without touching any bitmap data.

For every tile on a scan line, the fetcher makes two byte reads from the map memory and forms the reference from them. It then reads the one shape row chosen by the scan line's position inside the tile. The row's bits are shifted out one pixel per clock. The timing source supplies the pixel coordinate and an active flag. The pixel for a coordinate comes out exactly one tile width of clocks later, together with a valid flag.

The map memory holds several complete maps. A select input picks the map to show, and it is sampled only during vertical blanking. Processor writes share the single map port. A write goes through in any cycle in which the fetcher is not reading the map. In the other cycles the ready output is held low, which stalls the processor.

Top module: `tile_fetcher`

## Requirements
- R1: While `pix_valid` is high, `pix_out` equals bit (TILE-1 - x mod TILE) of the shape row for the coordinate (x, y) presented TILE clocks earlier. Bit TILE-1 of a row is the leftmost pixel. `pix_valid` equals `pix_en` delayed by TILE clocks.
- R2: A tile's map entry starts at byte address sel*COLS*ROWS*2 + ((y div TILE)*COLS + (x div TILE))*2. The fetcher reads that byte in the cycle where x mod TILE = 0 and `pix_en` is high. It reads the next byte up in the following cycle. The map memory returns read data one clock after the request.
- R3: The tile reference is formed low byte first: the byte at the even address is bits 7:0 and the byte at the odd address is bits 15:8.
- R4: The shape address is reference*TILE + (y mod TILE). It is issued in the cycle where x mod TILE = 2. Shape data returns one clock after the request and holds one row of TILE bits.
- R5: The displayed map changes only through `map_sel` sampled on a clock where `vblank` is high. A change of `map_sel` outside vertical blanking has no effect.
- R6: `cpu_ready` is low exactly in the cycles where `pix_en` is high and x mod TILE is 0 or 1. In any other cycle, a request on `cpu_wr_req` is written to the map memory at `cpu_addr` in that same cycle.
- R7: After reset, `pix_valid` and `pix_out` are 0, `cpu_ready` is 1 and map 0 is selected.
- R8: `pix_out` is 0 whenever `pix_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Coordinate valid; x advances by one per clock within a line |
| pix_x | input | X_W | Pixel column, line starts at a multiple of TILE |
| pix_y | input | Y_W | Scan line |
| vblank | input | 1 | Vertical blanking, map select sampled while high |
| map_sel | input | SEL_W | Requested map number |
| cpu_wr_req | input | 1 | Processor map write request |
| cpu_addr | input | MAP_AW | Processor write byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_ready | output | 1 | Write accepted this cycle when high |
| map_en | output | 1 | Map memory access strobe |
| map_we | output | 1 | Map memory write enable |
| map_addr | output | MAP_AW | Map memory byte address |
| map_wdata | output | 8 | Map memory write data |
| map_rdata | input | 8 | Map memory read data, one clock after request |
| shape_rd | output | 1 | Shape memory read strobe |
| shape_addr | output | SHP_AW | Shape memory row address |
| shape_rdata | input | TILE | Shape row, one clock after request |
| pix_out | output | 1 | Pixel value |
| pix_valid | output | 1 | Pixel valid |

## Verification
On every clock, assertions check the following. The high map byte is read at the address after the low byte. The shape address carries the low reference byte from the previous map read, the high byte from the current one, and the scan line's row within the tile. The map select holds outside blanking. A stalled processor write never reaches the memory port. Only the bench sweep can show the pixel stream itself: every pixel of every tile compared against arithmetic expectations for two maps. It also shows that a select change outside blanking leaves the picture alone, and that writes accepted during active display land and later appear on screen.

// File: rtl/tf_pkg.sv
package tf_pkg;
   typedef enum logic {
      TF_LO_FIRST = 1'b0,
      TF_HI_FIRST = 1'b1
   } tf_order_e;

   function automatic int tf_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tf_map_fetch.sv
module tf_map_fetch
   import tf_pkg::*;
#(
   parameter int COLS   = 80,
   parameter int ROWS   = 60,
   parameter int MAP_AW = 15,
   parameter int COL_W  = 7,
   parameter int ROW_W  = 6,
   parameter int SEL_W  = 1,
   parameter int PH_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_en,
   input  logic [PH_W-1:0]   phase,
   input  logic [COL_W-1:0]  col,
   input  logic [ROW_W-1:0]  row,
   input  logic              vblank,
   input  logic [SEL_W-1:0]  map_sel,
   output logic              rd_en,
   output logic [MAP_AW-1:0] rd_addr
);
   localparam int MAP_BYTES = COLS * ROWS * 2;

   logic [SEL_W-1:0]  sel_q;
   logic [MAP_AW-1:0] entry;
   logic [MAP_AW-1:0] entry_q;
   logic              ph0;
   logic              ph1;

   assign ph0 = pix_en && (phase == PH_W'(0));
   assign ph1 = pix_en && (phase == PH_W'(1));

   always_ff @(posedge clk) begin
      if (rst)
         sel_q <= '0;
      else if (vblank)
         sel_q <= map_sel;
   end

   assign entry = MAP_AW'(sel_q) * MAP_AW'(MAP_BYTES)
                + (MAP_AW'(row) * MAP_AW'(COLS) + MAP_AW'(col)) * MAP_AW'(2);

   always_ff @(posedge clk) begin
      if (rst)
         entry_q <= '0;
      else if (ph0)
         entry_q <= entry;
   end

   assign rd_en   = ph0 || ph1;
   assign rd_addr = ph0 ? entry : entry_q + MAP_AW'(1);

   // map select moves only on blanking clocks
   p_sel_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !vblank |=> $stable(sel_q));

   // second byte read directly follows the first at the next address
   p_hi_after_lo_r2: assert property (@(posedge clk) disable iff (rst)
      (ph1 && $past(ph0)) |-> (rd_addr == $past(rd_addr) + MAP_AW'(1)));
endmodule

// File: rtl/tf_shape_fetch.sv
module tf_shape_fetch
   import tf_pkg::*;
#(
   parameter int        TILE   = 8,
   parameter int        PH_W   = 3,
   parameter int        SHP_AW = 19,
   parameter tf_order_e ORDER  = TF_LO_FIRST
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_en,
   input  logic [PH_W-1:0]   phase,
   input  logic [PH_W-1:0]   line_in_tile,
   input  logic [7:0]        map_rdata,
   input  logic [TILE-1:0]   shape_rdata,
   output logic              shape_rd,
   output logic [SHP_AW-1:0] shape_addr,
   output logic [TILE-1:0]   staged
);
   logic [7:0]      first_q;
   logic [PH_W-1:0] trow_q;
   logic [15:0]     tref;
   logic            ph0;
   logic            ph1;
   logic            ph3;
   logic [1:0]      age;

   assign ph0      = pix_en && (phase == PH_W'(0));
   assign ph1      = pix_en && (phase == PH_W'(1));
   assign shape_rd = pix_en && (phase == PH_W'(2));
   assign ph3      = pix_en && (phase == PH_W'(3));

   always_ff @(posedge clk) begin
      if (rst) begin
         first_q <= '0;
         trow_q  <= '0;
         staged  <= '0;
      end else begin
         if (ph0) trow_q  <= line_in_tile;
         if (ph1) first_q <= map_rdata;
         if (ph3) staged  <= shape_rdata;
      end
   end

   generate
      if (ORDER == TF_LO_FIRST) begin : g_lo_first
         assign tref = {map_rdata, first_q};
         p_ref_order_r3: assert property (@(posedge clk) disable iff (rst)
            shape_rd |-> (shape_addr[SHP_AW-1:PH_W] == {map_rdata, $past(map_rdata)}));
      end else begin : g_hi_first
         assign tref = {first_q, map_rdata};
         p_ref_order_r3: assert property (@(posedge clk) disable iff (rst)
            shape_rd |-> (shape_addr[SHP_AW-1:PH_W] == {$past(map_rdata), map_rdata}));
      end
   endgenerate

   assign shape_addr = SHP_AW'({tref, trow_q});

   always_ff @(posedge clk) begin
      if (rst)
         age <= '0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end

   // row inside the tile follows the scan line seen at the tile start
   p_shape_row_r4: assert property (@(posedge clk) disable iff (rst)
      (shape_rd && age >= 2'd2) |-> (shape_addr[PH_W-1:0] == $past(line_in_tile, 2)));
endmodule

// File: rtl/tf_pixel_shift.sv
module tf_pixel_shift #(
   parameter int TILE = 8,
   parameter int PH_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            pix_en,
   input  logic [PH_W-1:0] phase,
   input  logic [TILE-1:0] staged,
   output logic            pix_out,
   output logic            pix_valid
);
   logic [TILE-1:0] shreg;
   logic [TILE-1:0] vpipe;
   logic            load;

   assign load = pix_en && (phase == PH_W'(TILE - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         vpipe <= '0;
      end else begin
         vpipe <= {vpipe[TILE-2:0], pix_en};
         if (load)
            shreg <= staged;
         else
            shreg <= {shreg[TILE-2:0], 1'b0};
      end
   end

   assign pix_valid = vpipe[TILE-1];
   assign pix_out   = pix_valid & shreg[TILE-1];

   // a freshly loaded row presents its leftmost bit on the next clock
   p_load_left_r1: assert property (@(posedge clk) disable iff (rst)
      load |=> (pix_out == (pix_valid & $past(staged[TILE-1]))));
endmodule

// File: rtl/tile_fetcher.sv
module tile_fetcher
   import tf_pkg::*;
#(
   parameter int        COLS   = 80,
   parameter int        ROWS   = 60,
   parameter int        TILE   = 8,
   parameter int        MAPS   = 2,
   parameter int        MAP_AW = 15,
   parameter tf_order_e ORDER  = TF_LO_FIRST,
   localparam int       PH_W   = tf_bits(TILE),
   localparam int       X_W    = tf_bits(COLS * TILE),
   localparam int       Y_W    = tf_bits(ROWS * TILE),
   localparam int       SEL_W  = tf_bits(MAPS),
   localparam int       SHP_AW = 16 + PH_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_en,
   input  logic [X_W-1:0]    pix_x,
   input  logic [Y_W-1:0]    pix_y,
   input  logic              vblank,
   input  logic [SEL_W-1:0]  map_sel,
   input  logic              cpu_wr_req,
   input  logic [MAP_AW-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic              cpu_ready,
   output logic              map_en,
   output logic              map_we,
   output logic [MAP_AW-1:0] map_addr,
   output logic [7:0]        map_wdata,
   input  logic [7:0]        map_rdata,
   output logic              shape_rd,
   output logic [SHP_AW-1:0] shape_addr,
   input  logic [TILE-1:0]   shape_rdata,
   output logic              pix_out,
   output logic              pix_valid
);
   localparam int COL_W = X_W - PH_W;
   localparam int ROW_W = Y_W - PH_W;

   generate
      if (TILE < 4 || (TILE & (TILE - 1)) != 0) begin : g_bad_tile
         $error("tile_fetcher: TILE must be a power of two of at least 4");
      end
      if (MAPS * COLS * ROWS * 2 > (1 << MAP_AW)) begin : g_bad_map
         $error("tile_fetcher: MAP_AW too small for MAPS full maps");
      end
      if (COL_W < 1 || ROW_W < 1) begin : g_bad_grid
         $error("tile_fetcher: grid must span more than one tile");
      end
   endgenerate

   logic [PH_W-1:0]   phase;
   logic              disp_rd;
   logic [MAP_AW-1:0] disp_addr;
   logic [TILE-1:0]   staged;

   assign phase = pix_x[PH_W-1:0];

   tf_map_fetch #(
      .COLS(COLS), .ROWS(ROWS), .MAP_AW(MAP_AW),
      .COL_W(COL_W), .ROW_W(ROW_W), .SEL_W(SEL_W), .PH_W(PH_W)
   ) u_map (
      .clk(clk), .rst(rst), .pix_en(pix_en), .phase(phase),
      .col(pix_x[X_W-1:PH_W]), .row(pix_y[Y_W-1:PH_W]),
      .vblank(vblank), .map_sel(map_sel),
      .rd_en(disp_rd), .rd_addr(disp_addr)
   );

   tf_shape_fetch #(
      .TILE(TILE), .PH_W(PH_W), .SHP_AW(SHP_AW), .ORDER(ORDER)
   ) u_shape (
      .clk(clk), .rst(rst), .pix_en(pix_en), .phase(phase),
      .line_in_tile(pix_y[PH_W-1:0]), .map_rdata(map_rdata),
      .shape_rdata(shape_rdata), .shape_rd(shape_rd),
      .shape_addr(shape_addr), .staged(staged)
   );

   tf_pixel_shift #(
      .TILE(TILE), .PH_W(PH_W)
   ) u_shift (
      .clk(clk), .rst(rst), .pix_en(pix_en), .phase(phase),
      .staged(staged), .pix_out(pix_out), .pix_valid(pix_valid)
   );

   // the map port belongs to the display in its two fetch slots
   assign cpu_ready = !disp_rd;
   assign map_we    = cpu_wr_req && !disp_rd;
   assign map_en    = disp_rd || map_we;
   assign map_addr  = disp_rd ? disp_addr : cpu_addr;
   assign map_wdata = cpu_wdata;

   p_stall_blocks_r6: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr_req && !cpu_ready) |-> !map_we);

   p_write_path_r6: assert property (@(posedge clk) disable iff (rst)
      map_we |-> (map_en && map_addr == cpu_addr && map_wdata == cpu_wdata));
endmodule

// File: tb/tile_fetcher_test.sv
module tile_fetcher_test;
   localparam int COLS   = 6;
   localparam int ROWS   = 4;
   localparam int TILE   = 8;
   localparam int MAPS   = 2;
   localparam int MAP_AW = 8;
   localparam int XS     = COLS * TILE;
   localparam int YS     = ROWS * TILE;
   localparam int MBYTES = COLS * ROWS * 2;
   localparam int HBLANK = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pix_en = 1'b0;
   logic [5:0]  pix_x = '0;
   logic [4:0]  pix_y = '0;
   logic        vblank = 1'b0;
   logic [0:0]  map_sel = '0;
   logic        cpu_wr_req = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_ready;
   logic        map_en, map_we;
   logic [7:0]  map_addr, map_wdata;
   logic [7:0]  map_rdata = '0;
   logic        shape_rd;
   logic [18:0] shape_addr;
   logic [7:0]  shape_rdata = '0;
   logic        pix_out, pix_valid;

   always #10 clk = ~clk;

   tile_fetcher #(
      .COLS(COLS), .ROWS(ROWS), .TILE(TILE), .MAPS(MAPS), .MAP_AW(MAP_AW)
   ) uut (
      .clk(clk), .rst(rst), .pix_en(pix_en), .pix_x(pix_x), .pix_y(pix_y),
      .vblank(vblank), .map_sel(map_sel), .cpu_wr_req(cpu_wr_req),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .map_en(map_en), .map_we(map_we), .map_addr(map_addr),
      .map_wdata(map_wdata), .map_rdata(map_rdata), .shape_rd(shape_rd),
      .shape_addr(shape_addr), .shape_rdata(shape_rdata),
      .pix_out(pix_out), .pix_valid(pix_valid)
   );

   function automatic logic [7:0] shp(input int unsigned a);
      return 8'((a * 29) ^ (a >> 4) ^ 32'h5A);
   endfunction

   // memory models
   logic [7:0] mem [256];
   logic [7:0] exp_map [256];

   always @(posedge clk) begin
      if (map_en && map_we)   mem[map_addr] <= map_wdata;
      else if (map_en)        map_rdata <= mem[map_addr];
      if (shape_rd)           shape_rdata <= shp(32'(shape_addr));
   end

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // expected pixel ring, TILE-cycle latency
   logic exp_v [16];
   logic exp_p [16];
   int   step_n = 0;

   function automatic logic ref_pixel(input int x, input int y, input int sel);
      int e;
      int unsigned idx;
      logic [7:0] bits;
      e    = sel * MBYTES + ((y / TILE) * COLS + (x / TILE)) * 2;
      idx  = {exp_map[e + 1], exp_map[e]};
      bits = shp(idx * TILE + (y % TILE));
      return bits[TILE - 1 - (x % TILE)];
   endfunction

   task automatic step(input bit en, input int x, input int y, input int sel);
      int k;
      @(negedge clk);
      if (step_n >= TILE) begin
         k = (step_n - TILE) % 16;
         check(pix_valid == exp_v[k], "R1 valid", int'(pix_valid), int'(exp_v[k]));
         if (exp_v[k])
            check(pix_out == exp_p[k], "R1,R2,R3,R4 pixel", int'(pix_out), int'(exp_p[k]));
         else
            check(pix_out == 1'b0, "R8 blank", int'(pix_out), 0);
      end
      k = step_n % 16;
      exp_v[k] = en;
      exp_p[k] = en ? ref_pixel(x, y, sel) : 1'b0;
      pix_en = en;
      pix_x  = 6'(x);
      pix_y  = 5'(y);
      step_n++;
   endtask

   task automatic run_frame(input int sel);
      for (int y = 0; y < YS; y++)
         for (int x = 0; x < XS + HBLANK; x++)
            if (x < XS) step(1'b1, x, y, sel);
            else        step(1'b0, 0, y, sel);
   endtask

   task automatic blank_select(input int req, input int sel_now);
      map_sel = 1'(req);
      vblank  = 1'b1;
      step(1'b0, 0, 0, sel_now);
      step(1'b0, 0, 0, sel_now);
      vblank  = 1'b0;
      step(1'b0, 0, 0, sel_now);
   endtask

   // processor writes into map 0 while map 1 is on screen
   task automatic cpu_writer(input int count);
      for (int n = 0; n < count; n++) begin
         bit taken;
         logic exp_rdy;
         taken = 1'b0;
         @(negedge clk);
         cpu_wr_req = 1'b1;
         cpu_addr   = 8'(n);
         cpu_wdata  = 8'((n * 53) ^ 8'hC3);
         while (!taken) begin
            #1;
            exp_rdy = !(pix_en && (pix_x[2:0] == 3'd0 || pix_x[2:0] == 3'd1));
            check(cpu_ready == exp_rdy, "R6 ready", int'(cpu_ready), int'(exp_rdy));
            if (cpu_ready) begin
               taken = 1'b1;
               exp_map[n] = cpu_wdata;
            end
            @(negedge clk);
         end
         cpu_wr_req = 1'b0;
         repeat (n % 5) @(negedge clk);
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]     = 8'((i * 7 + 1) ^ (i >> 1));
         exp_map[i] = mem[i];
      end
      for (int i = 0; i < 16; i++) begin
         exp_v[i] = 1'b0;
         exp_p[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R7 reset state
      check(pix_valid == 1'b0, "R7 valid", int'(pix_valid), 0);
      check(pix_out == 1'b0, "R7 pixel", int'(pix_out), 0);
      check(cpu_ready == 1'b1, "R7 ready", int'(cpu_ready), 1);
      // R7: map 0 shown without any select
      run_frame(0);
      // R5: request map 1 outside blanking, picture stays on map 0
      map_sel = 1'b1;
      run_frame(0);
      blank_select(1, 0);
      run_frame(1);
      // R6: writes during active display of map 1
      fork
         run_frame(1);
         cpu_writer(MBYTES);
      join
      blank_select(0, 1);
      run_frame(0);
      step(1'b0, 0, 0, 0);
      repeat (TILE + 1) step(1'b0, 0, 0, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", step_n, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule